// File: doc/BRIEF.md
# Reseeding Stochastic Number Generator

This block turns an unsigned fixed-point fraction into a unipolar stochastic bit stream. Each stream bit comes from comparing the fraction with the current word of a maximal-length linear feedback shift register of the same width. A conversion runs for exactly one full register period, so the fraction of ones in the stream encodes the value at the precision of that period.

The register does not restart from a constant. A stored seed loads it at the start of each conversion, and that seed moves forward by one after every finished conversion. Two conversions of the same value therefore produce different streams with the same density. A chaotic iteration that feeds its result back through this block gets a small perturbation on every pass, which keeps it out of short cycles.

The stream leaves on a valid/ready interface. While `out_valid_o` is high and `out_ready_i` is low, the bit is back-pressured: the offered bit holds and the register does not advance. A bit counts as delivered only on a cycle where both are high. `out_valid_o` never depends on `out_ready_i`. Start and done are plain control pins.

Top module: `reseed_sng`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid_o` and `done_o` are 0.
- R2: A conversion begins only on a cycle where `start_i` is 1 and was 0 in the cycle before. A start held high after a conversion finishes does not begin another one.
- R3: Stream bit k equals 1 exactly when register word k is greater, as an unsigned number, than the latched value. Word 0 is the seed. Each later word is the previous word shifted one place toward the MSB, with bit 0 taking the XOR of the tap bits. For WIDTH 16 the taps are bits 15, 13, 12 and 10. For WIDTH 8 they are bits 7, 5, 4 and 3. For WIDTH 4 they are bits 3 and 2.
- R4: A conversion delivers exactly 2^WIDTH-1 bits, and the number of ones delivered equals 2^WIDTH-1 minus the latched value.
- R5: `value_i` is captured on the start cycle. Changes to it during a conversion have no effect on the stream.
- R6: A start rising edge that arrives while a conversion is running is ignored. It neither restarts nor lengthens the conversion.
- R7: When `out_valid_o` is 1 and `out_ready_i` is 0, in the next cycle `out_valid_o` stays 1, the bit is unchanged, and the sequence does not advance.
- R8: `done_o` is 1 for exactly one cycle: the cycle after the last bit is accepted. In that cycle `out_valid_o` is 0.
- R9: The seed is taken from `seed_i` during reset, with 0 replaced by 1. After each conversion it increases by one, and a result of 0 becomes 1. The next conversion starts from the new seed.
- R10: `out_valid_o` is 1 in every cycle from the one after the start cycle until the last bit is accepted, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request; a rising edge starts a conversion |
| value_i | input | WIDTH | Unsigned fraction to encode |
| seed_i | input | WIDTH | Initial seed, sampled while reset is high |
| out_ready_i | input | 1 | Downstream accepts the offered bit |
| out_valid_o | output | 1 | A stream bit is offered |
| out_bit_o | output | 1 | Stream bit |
| done_o | output | 1 | One-cycle pulse after the final bit is accepted |

## Verification
The assertions check on every cycle that a stalled bit holds, that the register never sits at zero during a conversion, that the latched value stays put, that done is a lone pulse with the output idle, that the seed changes at each done, and that an edge pulse never lasts two cycles. Whether every bit matches the register sequence, whether the count of ones equals the expected density, and whether the seed increments and wraps correctly from one conversion to the next can only be shown by the bench. It runs whole conversions against its own model of the sequence, with random stalls, a value and start that change under the block, a start held high, and reset seeds of zero and all-ones.

// File: rtl/rsng_pkg.sv
package rsng_pkg;

  // Feedback tap masks for the supported register widths (maximal length).
  function automatic logic [31:0] tap_mask(input int unsigned w);
    logic [31:0] m;
    case (w)
      4:       m = 32'h0000_000C;  // bits 3,2
      8:       m = 32'h0000_00B8;  // bits 7,5,4,3
      16:      m = 32'h0000_B400;  // bits 15,13,12,10
      default: m = 32'h0000_0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rsng_edge_detect.sv
module rsng_edge_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) level_q <= 1'b0;
    else       level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/rsng_lfsr.sv
module rsng_lfsr #(
  parameter int unsigned WIDTH = 16,
  parameter logic [31:0] MASK  = 32'h0000_B400
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] state_o
);
  localparam logic [WIDTH-1:0] TAPS = MASK[WIDTH-1:0];

  logic [WIDTH-1:0] state_q;
  logic             feedback;

  assign feedback = ^(state_q & TAPS);

  always_ff @(posedge clk_i) begin
    if (rst_i)       state_q <= '0;
    else if (load_i) state_q <= seed_i;
    else if (step_i) state_q <= {state_q[WIDTH-2:0], feedback};
  end

  assign state_o = state_q;
endmodule

// File: rtl/rsng_seed_reg.sv
module rsng_seed_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] init_i,
  input  logic             bump_i,
  output logic [WIDTH-1:0] seed_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] seed_q;
  logic [WIDTH-1:0] seed_inc;

  assign seed_inc = seed_q + ONE;

  always_ff @(posedge clk_i) begin
    if (rst_i)       seed_q <= (init_i == '0) ? ONE : init_i;
    else if (bump_i) seed_q <= (seed_inc == '0) ? ONE : seed_inc;
  end

  assign seed_o = seed_q;
endmodule

// File: rtl/reseed_sng.sv
module reseed_sng #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [WIDTH-1:0] value_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic             out_bit_o,
  output logic             done_o
);
  import rsng_pkg::*;

  localparam logic [31:0]      MASK     = tap_mask(WIDTH);
  localparam logic [WIDTH-1:0] LAST_IDX = {{(WIDTH-1){1'b1}}, 1'b0};
  localparam logic [WIDTH-1:0] CNT_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             rise;
  logic             launch, accept, finish;
  logic             busy_q, done_q;
  logic [WIDTH-1:0] cnt_q, value_q, seed, word;

  rsng_edge_detect u_edge (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .level_i(start_i),
    .rise_o (rise)
  );

  rsng_seed_reg #(.WIDTH(WIDTH)) u_seed (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .init_i(seed_i),
    .bump_i(finish),
    .seed_o(seed)
  );

  rsng_lfsr #(.WIDTH(WIDTH), .MASK(MASK)) u_lfsr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (launch),
    .seed_i (seed),
    .step_i (accept),
    .state_o(word)
  );

  assign launch = rise & ~busy_q;
  assign accept = busy_q & out_ready_i;
  assign finish = accept & (cnt_q == LAST_IDX);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      value_q <= '0;
    end else begin
      done_q <= finish;
      if (launch) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        value_q <= value_i;
      end else if (accept) begin
        cnt_q <= cnt_q + CNT_ONE;
        if (finish) busy_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = busy_q;
  assign out_bit_o   = busy_q & (word > value_q);
  assign done_o      = done_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_q |-> word != '0); // R3
  AST_VALUE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && $past(busy_q)) |-> $stable(value_q)); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_bit_o) && $stable(word))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !out_valid_o); // R8
  AST_SEED_MOVES: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> seed != $past(seed)); // R9
endmodule

// File: tb/test_reseed_sng.sv
`timescale 1ns/1ps
module test_reseed_sng;
  localparam int W      = 8;
  localparam int PERIOD = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_i, start_i, out_ready_i;
  logic [W-1:0] value_i, seed_i;
  logic         out_valid_o, out_bit_o, done_o;

  always #2 clk = ~clk;

  reseed_sng #(.WIDTH(W)) i_reseed_sng (
    .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .value_i(value_i),
    .seed_i(seed_i), .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
    .out_bit_o(out_bit_o), .done_o(done_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] seed_m;

  function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
    return {s[W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [W-1:0] seed_next(input logic [W-1:0] s);
    logic [W-1:0] t;
    t = s + 1'b1;
    return (t == '0) ? 8'd1 : t;
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      if (n_bad <= 20)
        $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_reset(input logic [W-1:0] s);
    rst_i = 1'b1; seed_i = s; start_i = 1'b0; out_ready_i = 1'b0; value_i = '0;
    repeat (3) @(negedge clk);
    check_eq("R1", "valid in reset", int'(out_valid_o), 0);
    check_eq("R1", "done in reset", int'(done_o), 0);
    rst_i = 1'b0;
    seed_m = (s == '0) ? 8'd1 : s;
    @(negedge clk);
    check_eq("R1", "valid after reset", int'(out_valid_o), 0);
    check_eq("R1", "done after reset", int'(done_o), 0);
  endtask

  // One full conversion; caller is aligned to a negedge.
  task automatic run_conv(input logic [W-1:0] val, input int ready_pct,
                          input bit hold_start, input bit noise);
    logic [W-1:0] m;
    int acc, ones;
    bit first, stalled;
    start_i = 1'b1; value_i = val;
    @(negedge clk);
    if (!hold_start) start_i = 1'b0;
    m = seed_m; acc = 0; ones = 0; first = 1'b1; stalled = 1'b0;
    while (acc < PERIOD) begin
      check_eq("R10", "valid during conversion", int'(out_valid_o), 1);
      check_eq(first ? "R9" : (stalled ? "R7" : (noise ? "R5" : "R3")),
               "stream bit", int'(out_bit_o), int'(m > val));
      first = 1'b0;
      if (noise) begin
        value_i = W'($urandom);
        if (!hold_start) start_i = 1'($urandom);   // R6: edges mid-conversion
      end
      out_ready_i = (($urandom % 100) < ready_pct);
      stalled = !out_ready_i;
      if (out_ready_i) begin
        ones += int'(out_bit_o);
        m = lfsr_next(m);
        acc++;
      end
      @(negedge clk);
    end
    out_ready_i = 1'b0;
    if (!hold_start) start_i = 1'b0;
    check_eq(noise ? "R6" : "R8", "done after last bit", int'(done_o), 1);
    check_eq("R8", "valid in done cycle", int'(out_valid_o), 0);
    check_eq("R4", "ones in stream", ones, PERIOD - int'(val));
    @(negedge clk);
    check_eq("R8", "done single cycle", int'(done_o), 0);
    if (hold_start) begin
      repeat (4) begin
        check_eq("R2", "held start idle", int'(out_valid_o), 0);
        @(negedge clk);
      end
      start_i = 1'b0;
      @(negedge clk);
    end
    seed_m = seed_next(seed_m);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(8'h00);                 // R9: zero seed becomes 1
    run_conv(8'h00, 100, 1'b0, 1'b0); // all ones
    run_conv(8'hFF, 100, 1'b0, 1'b0); // all zeros
    run_conv(8'h80, 100, 1'b1, 1'b0); // held start
    run_conv(8'h80, 50, 1'b0, 1'b0);  // same value, new seed, stalls
    for (int i = 0; i < 6; i++)
      run_conv(W'($urandom), 40 + int'($urandom % 60), 1'b0, (i % 2) == 1);
    do_reset(8'hFF);                 // R9: wrap from all-ones to 1
    run_conv(8'h3C, 70, 1'b0, 1'b1);
    run_conv(8'h3C, 100, 1'b0, 1'b0);
    run_conv(8'hFE, 60, 1'b0, 1'b0);
    summary();
    $finish;
  end
endmodule